// File: doc/BRIEF.md
# Packet Buffer Pointer and Byte Data Port

This block gives a host processor byte-wide access into fixed-size packet pages held in an external buffer memory. The host loads a 16-bit pointer register one byte at a time. The pointer holds a byte offset inside a page plus a few mode flags. The host then reads or writes one of four data register addresses. For each data access the block decides which page is meant and which byte inside it. It drives a page index and byte address to the memory, and it moves the pointer forward when automatic stepping is enabled.

The page comes from one of two external sources. It is either the value of the packet-number register or the entry at the head of the receive queue, depending on a flag in the pointer. With stepping enabled, every data access uses the stored offset and then advances it by one. The offset wraps inside the page and the flags are left alone. With stepping disabled, the two low bits of the data register address are added to the stored offset, and the pointer is not changed. The host bus splits a wider access into byte accesses, lowest address first, so a word access steps the pointer once per byte.

Top module: `pkt_ptr_port`

## Requirements
- R1: After reset the pointer is 0x0000, so reads of offset 6 and offset 7 both return 0x00.
- R2: A write to offset 6 replaces pointer bits 7:0 and keeps bits 15:8. A write to offset 7 replaces bits 15:8 and keeps bits 7:0.
- R3: A read of offset 6 returns pointer bits 7:0. A read of offset 7 returns pointer bits 15:8 with bit 11 (the not-empty flag, bit 3 of that byte) forced to 0.
- R4: An access to a data offset (8 to 11) addresses page `rxq_head` when pointer bit 15 (receive) is set, and page `pkt_num` otherwise.
- R5: With pointer bit 14 (step) set, a valid data access uses byte address = pointer bits 10:0. Afterwards bits 10:0 become (old + 1) mod 2048, and bits 15:11 are unchanged.
- R6: With bit 14 clear, a data access at offset 8+k (k = 0..3) uses byte address (pointer bits 10:0 + k) mod 2048, and the pointer is unchanged.
- R7: If the selected page number is 4 or more, a data write does not assert `mem_we`, a data read returns 0x00, and the pointer does not advance.
- R8: A read strobe and a write strobe together at one data offset form a single access. The read returns the byte stored at the addressed location before the write, the write goes to that same location, and the step advances the pointer by exactly one.
- R9: Writes to offsets 0 to 5 and 12 to 15 leave the pointer unchanged, and reads of those offsets return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host byte write strobe |
| rd_en | input | 1 | Host byte read strobe |
| reg_off | input | 4 | Register offset of the access |
| wr_data | input | 8 | Host write byte |
| rd_data | output | 8 | Host read byte; 0x00 when no read is made |
| pkt_num | input | 8 | Current packet-number register |
| rxq_head | input | 8 | Page number at the head of the receive queue |
| mem_page | output | 2 | Page index to buffer memory |
| mem_addr | output | 11 | Byte address within the page |
| mem_we | output | 1 | Buffer memory byte write enable |
| mem_re | output | 1 | Buffer memory read enable |
| mem_wdata | output | 8 | Byte written to buffer memory |
| mem_rdata | input | 8 | Byte read from buffer memory (combinational) |

## Verification
Two things can land in the same clock cycle: the stepped offset wrapping from 2047 to 0, and the requirement that the flag bits above it stay fixed. The bench provokes this by loading the offset just below the top of the page with every flag set, then stepping through the wrap with consecutive data accesses. It compares both the memory addresses and the read-back pointer with values worked out from the arithmetic. A second same-cycle case is a read and a write issued together at one data offset. This is judged by checking that the returned byte is the old memory content, that the write lands at the same address, and that the pointer moves by one.

// File: rtl/pkt_ptr_pkg.sv
package pkt_ptr_pkg;
   localparam int PTR_W     = 16;
   localparam int RX_BIT    = 15;
   localparam int STEP_BIT  = 14;
   localparam logic [3:0] OFF_PTR_LO = 4'd6;
   localparam logic [3:0] OFF_PTR_HI = 4'd7;
   localparam logic [1:0] DATA_SEL   = 2'b10;   // reg_off[3:2] for offsets 8..11

   typedef enum logic [1:0] {
      ACC_NONE,
      ACC_PTR,
      ACC_DATA
   } acc_kind_e;
endpackage

// File: rtl/pkt_ptr_reg.sv
module pkt_ptr_reg
   import pkt_ptr_pkg::*;
#(
   parameter int OFS_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic [7:0]       wdata,
   input  logic             step,
   output logic [PTR_W-1:0] ptr
);
   localparam int FLG_W = PTR_W - OFS_W;

   generate
      if (OFS_W < 9 || OFS_W > 12) begin : g_bad_ofs
         $error("pkt_ptr_reg: OFS_W must be 9..12");
      end
   endgenerate

   logic [OFS_W-1:0] ofs_next;
   assign ofs_next = ptr[OFS_W-1:0] + OFS_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (wr_lo) begin
         ptr <= {ptr[PTR_W-1:8], wdata};
      end else if (wr_hi) begin
         ptr <= {wdata, ptr[7:0]};
      end else if (step) begin
         ptr <= {ptr[PTR_W-1 -: FLG_W], ofs_next};
      end
   end
endmodule

// File: rtl/pkt_ptr_addr.sv
module pkt_ptr_addr
   import pkt_ptr_pkg::*;
#(
   parameter int OFS_W = 11,
   parameter int PAGES = 4,
   parameter int PN_W  = 8,
   localparam int PG_W = (PAGES > 1) ? $clog2(PAGES) : 1
) (
   input  logic [PTR_W-1:0] ptr,
   input  logic [1:0]       lane,
   input  logic [PN_W-1:0]  pkt_num,
   input  logic [PN_W-1:0]  rxq_head,
   output logic [PG_W-1:0]  page,
   output logic [OFS_W-1:0] addr,
   output logic             page_ok
);
   logic [PN_W-1:0] pnum;

   generate
      if (PN_W <= PG_W) begin : g_bad_pn
         $error("pkt_ptr_addr: PN_W must exceed page index width");
      end
   endgenerate

   assign pnum = ptr[RX_BIT] ? rxq_head : pkt_num;
   assign page = pnum[PG_W-1:0];

   // range check: power-of-two page counts only need the upper bits zero
   generate
      if ((1 << PG_W) == PAGES) begin : g_pow2
         assign page_ok = (pnum[PN_W-1:PG_W] == '0);
      end else begin : g_cmp
         assign page_ok = (pnum < PN_W'(PAGES));
      end
   endgenerate

   // stepping mode uses the stored offset; fixed mode adds the lane
   always_comb begin
      if (ptr[STEP_BIT]) addr = ptr[OFS_W-1:0];
      else               addr = ptr[OFS_W-1:0] + OFS_W'(lane);
   end
endmodule

// File: rtl/pkt_ptr_port.sv
module pkt_ptr_port
   import pkt_ptr_pkg::*;
#(
   parameter int OFS_W = 11,
   parameter int PAGES = 4,
   parameter int PN_W  = 8,
   localparam int PG_W = (PAGES > 1) ? $clog2(PAGES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [3:0]       reg_off,
   input  logic [7:0]       wr_data,
   output logic [7:0]       rd_data,
   input  logic [PN_W-1:0]  pkt_num,
   input  logic [PN_W-1:0]  rxq_head,
   output logic [PG_W-1:0]  mem_page,
   output logic [OFS_W-1:0] mem_addr,
   output logic             mem_we,
   output logic             mem_re,
   output logic [7:0]       mem_wdata,
   input  logic [7:0]       mem_rdata
);
   localparam int NE_IN_HI = OFS_W - 8;   // not-empty flag inside the high byte

   acc_kind_e        kind;
   logic [PTR_W-1:0] ptr_q;
   logic             page_ok;
   logic             data_acc;
   logic             step;
   logic [7:0]       hi_rd;

   always_comb begin
      if (reg_off[3:2] == DATA_SEL)                          kind = ACC_DATA;
      else if (reg_off == OFF_PTR_LO || reg_off == OFF_PTR_HI) kind = ACC_PTR;
      else                                                    kind = ACC_NONE;
   end

   assign data_acc = (wr_en | rd_en) && (kind == ACC_DATA);
   assign step     = data_acc && page_ok && ptr_q[STEP_BIT];

   pkt_ptr_reg #(.OFS_W(OFS_W)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_lo (wr_en && reg_off == OFF_PTR_LO),
      .wr_hi (wr_en && reg_off == OFF_PTR_HI),
      .wdata (wr_data),
      .step  (step),
      .ptr   (ptr_q)
   );

   pkt_ptr_addr #(.OFS_W(OFS_W), .PAGES(PAGES), .PN_W(PN_W)) u_addr (
      .ptr      (ptr_q),
      .lane     (reg_off[1:0]),
      .pkt_num  (pkt_num),
      .rxq_head (rxq_head),
      .page     (mem_page),
      .addr     (mem_addr),
      .page_ok  (page_ok)
   );

   assign mem_we    = wr_en && data_acc && page_ok;
   assign mem_re    = rd_en && data_acc && page_ok;
   assign mem_wdata = wr_data;

   always_comb begin
      hi_rd = ptr_q[PTR_W-1:8];
      hi_rd[NE_IN_HI] = 1'b0;
   end

   always_comb begin
      rd_data = 8'h00;
      if (rd_en) begin
         unique case (kind)
            ACC_PTR:  rd_data = reg_off[0] ? hi_rd : ptr_q[7:0];
            ACC_DATA: rd_data = page_ok ? mem_rdata : 8'h00;
            default:  rd_data = 8'h00;
         endcase
      end
   end

   // R5
   step_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> ptr_q[OFS_W-1:0] == $past(mem_addr) + OFS_W'(1));

   // R5
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_acc |=> ptr_q[PTR_W-1:OFS_W] == $past(ptr_q[PTR_W-1:OFS_W]));

   // R6
   fixed_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_acc && !ptr_q[STEP_BIT]) |=> $stable(ptr_q));

   // R7
   bad_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_acc && !page_ok) |-> (!mem_we && rd_data == 8'h00));

   // R7
   bad_page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_acc && !page_ok) |=> $stable(ptr_q));

   // R9
   other_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && kind == ACC_NONE) |=> $stable(ptr_q));
endmodule

// File: tb/test_pkt_ptr_port.sv
module test_pkt_ptr_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [3:0]  reg_off = '0;
   logic [7:0]  wr_data = '0;
   logic [7:0]  rd_data;
   logic [7:0]  pkt_num = '0, rxq_head = '0;
   logic [1:0]  mem_page;
   logic [10:0] mem_addr;
   logic        mem_we, mem_re;
   logic [7:0]  mem_wdata, mem_rdata;

   int n_vec = 0, n_bad = 0;
   bit done = 0;

   // buffer contents modelled as a fixed pattern of page and address
   function automatic logic [7:0] patt(input logic [1:0] p, input logic [10:0] a);
      return (8'(p) * 8'h53) ^ a[7:0] ^ {5'b0, a[10:8]};
   endfunction
   assign mem_rdata = patt(mem_page, mem_addr);

   pkt_ptr_port i_pkt_ptr_port (.*);

   always #2 clk = ~clk;

   initial begin : watchdog
      #400000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: act=hung exp=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
      end
   endtask

   // one access; samples the combinational outputs before the edge
   logic [7:0]  s_rd;
   logic        s_we;
   logic [1:0]  s_pg;
   logic [10:0] s_ad;
   logic [7:0]  s_wd;
   task automatic acc(input bit w, input bit r, input logic [3:0] off, input logic [7:0] d);
      @(negedge clk);
      wr_en = w; rd_en = r; reg_off = off; wr_data = d;
      #1;
      s_rd = rd_data; s_we = mem_we; s_pg = mem_page; s_ad = mem_addr; s_wd = mem_wdata;
      @(posedge clk);
      #1;
      wr_en = 0; rd_en = 0;
   endtask

   task automatic set_ptr(input logic [15:0] v);
      acc(1, 0, 4'd6, v[7:0]);
      acc(1, 0, 4'd7, v[15:8]);
   endtask

   task automatic get_ptr(output logic [15:0] v);
      acc(0, 1, 4'd6, 8'h00); v[7:0]  = s_rd;
      acc(0, 1, 4'd7, 8'h00); v[15:8] = s_rd;
   endtask

   initial begin : stim
      logic [15:0] pv;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      get_ptr(pv);
      check("R1 reset ptr", pv, 16'h0000);

      // R2 / R3 byte writes keep the other byte, high read masks bit 11
      set_ptr(16'hA5C3);
      acc(1, 0, 4'd6, 8'h3C);
      get_ptr(pv);
      check("R2 low write keeps high", pv, 16'hA53C & 16'hF7FF);
      acc(1, 0, 4'd7, 8'hFF);
      get_ptr(pv);
      check("R2 high write keeps low", pv[7:0], 8'h3C);
      check("R3 high read masks not-empty", pv[15:8], 8'hF7);

      // R4 page selection sweep, fixed mode, write at offset 8
      for (int rx = 0; rx < 2; rx++)
         for (int pn = 0; pn < 6; pn++)
            for (int rh = 0; rh < 6; rh++) begin
               int sel;
               pkt_num = 8'(pn); rxq_head = 8'(rh);
               set_ptr(rx ? 16'h8010 : 16'h0010);
               acc(1, 0, 4'd8, 8'(pn * 16 + rh));
               sel = rx ? rh : pn;
               check("R4/R7 write enable", s_we, sel < 4);
               if (sel < 4) begin
                  check("R4 page", s_pg, sel);
                  check("R4 data", s_wd, pn * 16 + rh);
               end
            end

      // R6 fixed mode: offset plus lane, wrapped; pointer unchanged
      pkt_num = 8'd2; rxq_head = 8'd0;
      foreach (pv[i]) begin end
      for (int oi = 0; oi < 4; oi++) begin
         int ofs;
         ofs = (oi == 0) ? 0 : (oi == 1) ? 5 : (oi == 2) ? 2046 : 2047;
         for (int k = 0; k < 4; k++) begin
            logic [15:0] pr;
            set_ptr(16'h2000 | 16'(ofs));
            acc(0, 1, 4'(8 + k), 8'h00);
            check("R6 addr", s_ad, (ofs + k) % 2048);
            check("R6 read data", s_rd, patt(2'd2, 11'((ofs + k) % 2048)));
            get_ptr(pr);
            check("R6 ptr unchanged", pr, 16'h2000 | 16'(ofs));
         end
      end

      // R5 stepping across the wrap with all flags set (rx page 1)
      rxq_head = 8'd1;
      set_ptr(16'hFFFD);   // offset 2045, every flag bit set
      for (int k = 0; k < 4; k++) begin
         acc(0, 1, 4'(8 + k), 8'h00);
         check("R5 step addr", s_ad, (2045 + k) % 2048);
         check("R5 step data", s_rd, patt(2'd1, 11'((2045 + k) % 2048)));
      end
      get_ptr(pv);
      check("R5 flags kept after wrap", pv, 16'hF001);

      // R8 read and write together: one step, old data, same address
      pkt_num = 8'd3;
      set_ptr(16'h4000 | 16'd100);
      acc(1, 1, 4'd9, 8'h77);
      check("R8 read old byte", s_rd, patt(2'd3, 11'd100));
      check("R8 write addr", s_ad, 100);
      check("R8 write enable", s_we, 1);
      get_ptr(pv);
      check("R8 single step", pv, 16'h4000 | 16'd101);

      // R7 invalid page in stepping mode: read 0, no write, no step
      pkt_num = 8'd4;
      set_ptr(16'h4000 | 16'd7);
      acc(0, 1, 4'd8, 8'h00);
      check("R7 read zero", s_rd, 0);
      acc(1, 0, 4'd10, 8'h99);
      check("R7 no write", s_we, 0);
      get_ptr(pv);
      check("R7 no step", pv, 16'h4007);

      // R9 other offsets: no pointer change, reads zero
      set_ptr(16'h1234);
      for (int o = 0; o < 16; o++) begin
         if (o >= 6 && o <= 11) continue;
         acc(1, 0, 4'(o), 8'hEE);
         acc(0, 1, 4'(o), 8'h00);
         check("R9 read zero", s_rd, 0);
      end
      get_ptr(pv);
      check("R9 ptr unchanged", pv, 16'h1234);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule